// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the instruction-fetch address and the data-access address of a processor core. It compares both against four programmable breakpoint addresses. When a breakpoint slot that software has armed sees its condition, the block sets a sticky flag for that slot and raises a one-cycle request for the debug exception (vector 1). A handler reads the flags to learn which slot fired, and writes zeros to clear the flags it has dealt with.

Each slot has its own enable pair. One enable is local and is dropped automatically when the core switches task. The other is global and survives task switches. A local and a global exact-match bit work the same way. While either exact-match bit is set, the block asks the core to hold the next instruction until the current data operand transfer has finished, so a data breakpoint is reported against the instruction that caused it. Every register is written through one narrow write port. The flags are read back directly on an output.

Top module: `bpm_unit`

## Requirements
- R1: A slot is armed when its local enable (control bit i) or its global enable (control bit 4+i) is set. A condition met on a disarmed slot sets no flag and raises no exception request.
- R2: When an armed slot of kind execute (kind code 00) sees `fetch_valid` with a matching `fetch_addr`, `dbg_exc_o` is high in the following cycle and status bit i is set in that same cycle.
- R3: The slot span field (control bits 18+4i and 19+4i) selects the compare width. Code 00 compares every address bit. Code 01 ignores address bit 0. Codes 11 and 10 ignore address bits 1 and 0.
- R4: Kind 01 matches only data accesses with `data_write` high. Kind 11 matches data reads and data writes. Kind 00 never matches data accesses, kinds 01 and 11 never match fetches, and kind 10 never matches. The kind field sits at control bits 16+4i and 17+4i.
- R5: Status flags are sticky. A write to selector 5 keeps flag i only where bit i of the written data is 1. No other event clears a flag, and a hit in the same cycle as a clearing write still sets its flag.
- R6: When several armed slots hit in one cycle, all of their flags are set together and `dbg_exc_o` is high for exactly one cycle. It stays low in the next cycle if nothing hits then.
- R7: A `task_switch` pulse clears every local enable and the local exact-match bit (control bit 8). It keeps the global enables and the global exact-match bit (control bit 9). This is applied after a control write in the same cycle.
- R8: `exact_stall_o` is high exactly while control bit 8 or control bit 9 is set.
- R9: Reset clears all enables, both exact-match bits, all flags, the exception request and the stall request.
- R10: Register selectors: 0 to 3 write the breakpoint address of slots 0 to 3, 4 writes the control word, and 5 is the flag-clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register selector |
| reg_wr_data | input | 32 | Register write data |
| task_switch | input | 1 | One-cycle pulse when the core changes task |
| fetch_valid | input | 1 | Instruction fetch address is valid |
| fetch_addr | input | 32 | Instruction fetch address |
| data_valid | input | 1 | Data access address is valid |
| data_addr | input | 32 | Data access address |
| data_write | input | 1 | Data access is a write (low for read) |
| dbg_exc_o | output | 1 | Debug exception request pulse |
| exact_stall_o | output | 1 | Hold next instruction until data transfer completes |
| status_o | output | 4 | Sticky per-slot hit flags |

## Verification
The bench checks addresses that differ from a breakpoint only in the ignored low bits, and addresses just beyond the span. A design that masked the wrong bits would either miss the first or report the second. Kind checks use reads against write-only slots and data accesses against execute slots, so a design that ignored the qualifier would raise spurious exceptions. Task switches are sent both with locally and with globally enabled slots active. A design that cleared the wrong set of bits would either keep firing on a local slot or drop the stall request that the global exact bit holds. Two slots are also made to hit together, to catch a request that stretches over two cycles or a flag that is lost.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    localparam int MAX_SLOT = 4;
    localparam int REG_W    = 32;
    localparam int SEL_W    = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

    typedef enum logic [1:0] {
        KIND_EXEC = 2'b00,
        KIND_WR   = 2'b01,
        KIND_NONE = 2'b10,
        KIND_RDWR = 2'b11
    } bp_kind_e;

    typedef enum logic [1:0] {
        SPAN_1 = 2'b00,
        SPAN_2 = 2'b01,
        SPAN_X = 2'b10,
        SPAN_4 = 2'b11
    } bp_span_e;

    typedef struct packed {
        bp_span_e span;
        bp_kind_e kind;
    } slot_cfg_t;

    typedef struct packed {
        slot_cfg_t [MAX_SLOT-1:0] cfg;
        logic [5:0]               rsvd;
        logic                     glb_exact;
        logic                     loc_exact;
        logic [MAX_SLOT-1:0]      glb_en;
        logic [MAX_SLOT-1:0]      loc_en;
    } ctrl_word_t;

    // low address bits left out of the compare for a given span
    function automatic logic [1:0] span_ignore(input bp_span_e s);
        case (s)
            SPAN_1:  return 2'b00;
            SPAN_2:  return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/bpm_regs.sv
module bpm_regs
    import bpm_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int AW    = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     task_switch,
    output logic [NSLOT-1:0][AW-1:0] base_o,
    output ctrl_word_t               ctrl_o
);

    ctrl_word_t ctrl_q;
    ctrl_word_t ctrl_d;
    logic [NSLOT-1:0][AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (wr_en && wr_sel == SEL_W'(i))
                    base_q[i] <= wr_data[AW-1:0];
            end
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_sel == SEL_CTRL) begin
            ctrl_d      = ctrl_word_t'(wr_data);
            ctrl_d.rsvd = '0;
        end
        // task switch wins over a same-cycle write for the local bits
        if (task_switch) begin
            ctrl_d.loc_en    = '0;
            ctrl_d.loc_exact = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign base_o = base_q;
    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/bpm_slot.sv
module bpm_slot
    import bpm_pkg::*;
#(
    parameter int AW = 32
) (
    input  slot_cfg_t     cfg,
    input  logic [AW-1:0] base,
    input  logic          armed,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          data_valid,
    input  logic [AW-1:0] data_addr,
    input  logic          data_write,
    output logic          hit
);

    logic [AW-1:0] keep;
    logic          fetch_eq;
    logic          data_eq;
    logic          cond;

    assign keep     = ~AW'(span_ignore(cfg.span));
    assign fetch_eq = ((fetch_addr ^ base) & keep) == '0;
    assign data_eq  = ((data_addr ^ base) & keep) == '0;

    always_comb begin
        case (cfg.kind)
            KIND_EXEC: cond = fetch_valid && fetch_eq;
            KIND_WR:   cond = data_valid && data_write && data_eq;
            KIND_RDWR: cond = data_valid && data_eq;
            default:   cond = 1'b0;
        endcase
    end

    assign hit = armed && cond;

endmodule

// File: rtl/bpm_status.sv
module bpm_status
    import bpm_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] hit,
    input  logic             clr_en,
    input  logic [NSLOT-1:0] clr_keep,
    output logic [NSLOT-1:0] status_o,
    output logic             exc_o
);

    logic [NSLOT-1:0] flags_q;
    logic [NSLOT-1:0] kept;
    logic             exc_q;

    assign kept = clr_en ? (flags_q & clr_keep) : flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            exc_q   <= 1'b0;
        end else begin
            flags_q <= kept | hit;
            exc_q   <= |hit;
        end
    end

    assign status_o = flags_q;
    assign exc_o    = exc_q;

endmodule

// File: rtl/bpm_unit.sv
module bpm_unit
    import bpm_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_wr_sel,
    input  logic [31:0]      reg_wr_data,
    input  logic             task_switch,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    fetch_addr,
    input  logic             data_valid,
    input  logic [AW-1:0]    data_addr,
    input  logic             data_write,
    output logic             dbg_exc_o,
    output logic             exact_stall_o,
    output logic [NSLOT-1:0] status_o
);

    logic [NSLOT-1:0][AW-1:0] base;
    ctrl_word_t               ctrl_q;
    logic [NSLOT-1:0]         armed;
    logic [NSLOT-1:0]         hit;

    bpm_regs #(.NSLOT(NSLOT), .AW(AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr_en),
        .wr_sel      (reg_wr_sel),
        .wr_data     (reg_wr_data),
        .task_switch (task_switch),
        .base_o      (base),
        .ctrl_o      (ctrl_q)
    );

    assign armed = ctrl_q.loc_en[NSLOT-1:0] | ctrl_q.glb_en[NSLOT-1:0];

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            bpm_slot #(.AW(AW)) u_slot (
                .cfg         (ctrl_q.cfg[i]),
                .base        (base[i]),
                .armed       (armed[i]),
                .fetch_valid (fetch_valid),
                .fetch_addr  (fetch_addr),
                .data_valid  (data_valid),
                .data_addr   (data_addr),
                .data_write  (data_write),
                .hit         (hit[i])
            );
        end
    endgenerate

    bpm_status #(.NSLOT(NSLOT)) u_status (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .clr_en   (reg_wr_en && reg_wr_sel == SEL_STAT),
        .clr_keep (reg_wr_data[NSLOT-1:0]),
        .status_o (status_o),
        .exc_o    (dbg_exc_o)
    );

    assign exact_stall_o = ctrl_q.loc_exact | ctrl_q.glb_exact;

endmodule

// File: rtl/bpm_unit_chk.sv
module bpm_unit_chk #(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [2:0]       reg_wr_sel,
    input logic             task_switch,
    input logic             dbg_exc_o,
    input logic             exact_stall_o,
    input logic [NSLOT-1:0] status_o,
    input logic [NSLOT-1:0] loc_en,
    input logic             loc_exact
);

    AST_EXC_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        dbg_exc_o |-> (status_o != '0)); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_wr_sel == 3'd5) |=> ((status_o & $past(status_o)) == $past(status_o))); // R5

    AST_TS_DROPS_LOCAL: assert property (@(posedge clk) disable iff (rst)
        task_switch |=> (loc_en == '0 && !loc_exact)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (status_o == '0 && !dbg_exc_o && !exact_stall_o)); // R9

endmodule

bind bpm_unit bpm_unit_chk #(.NSLOT(NSLOT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_sel    (reg_wr_sel),
    .task_switch   (task_switch),
    .dbg_exc_o     (dbg_exc_o),
    .exact_stall_o (exact_stall_o),
    .status_o      (status_o),
    .loc_en        (ctrl_q.loc_en[NSLOT-1:0]),
    .loc_exact     (ctrl_q.loc_exact)
);

// File: tb/bpm_unit_bench.sv
module bpm_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic        task_switch = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        data_valid = 1'b0;
    logic [31:0] data_addr = '0;
    logic        data_write = 1'b0;
    logic        dbg_exc_o;
    logic        exact_stall_o;
    logic [3:0]  status_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl;
    logic [3:0]  m_stat;

    always #10 clk = ~clk;

    bpm_unit u_bpm_unit (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .task_switch(task_switch),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .data_valid(data_valid), .data_addr(data_addr), .data_write(data_write),
        .dbg_exc_o(dbg_exc_o), .exact_stall_o(exact_stall_o), .status_o(status_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_hits(input logic fv, input logic [31:0] fa,
                                            input logic dv, input logic [31:0] da,
                                            input logic dw);
        logic [3:0] h = '0;
        for (int i = 0; i < 4; i++) begin
            logic        arm  = m_ctrl[i] | m_ctrl[4+i];
            logic [1:0]  kind = m_ctrl[16+4*i +: 2];
            logic [1:0]  span = m_ctrl[18+4*i +: 2];
            logic [31:0] ign  = (span == 2'b00) ? 32'd0 : (span == 2'b01) ? 32'd1 : 32'd3;
            logic        feq  = ((fa ^ m_addr[i]) & ~ign) == 0;
            logic        deq  = ((da ^ m_addr[i]) & ~ign) == 0;
            logic        c;
            case (kind)
                2'b00:   c = fv && feq;
                2'b01:   c = dv && dw && deq;
                2'b11:   c = dv && deq;
                default: c = 1'b0;
            endcase
            h[i] = arm && c;
        end
        return h;
    endfunction

    function automatic logic m_stall();
        return m_ctrl[8] | m_ctrl[9];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_addr[i] = '0;
        m_ctrl = '0;
        m_stat = '0;
    endtask

    // register write; inputs driven at negedge, results checked one negedge later
    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input string tag);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (sel < 3'd4) m_addr[sel] = d;
        else if (sel == 3'd4) m_ctrl = d & 32'hFFFF_03FF;
        else if (sel == 3'd5) m_stat = m_stat & d[3:0];
        chk({tag, " status after write"}, 32'(status_o), 32'(m_stat));
        chk({tag, " stall after write"}, 32'(exact_stall_o), 32'(m_stall()));
    endtask

    task automatic tswitch(input string tag);
        task_switch = 1'b1;
        @(negedge clk);
        task_switch = 1'b0;
        m_ctrl = m_ctrl & ~32'h0000_010F;
        chk({tag, " stall after task switch"}, 32'(exact_stall_o), 32'(m_stall()));
    endtask

    task automatic acc(input logic fv, input logic [31:0] fa, input logic dv,
                       input logic [31:0] da, input logic dw, input logic [3:0] exp,
                       input string tag);
        fetch_valid = fv; fetch_addr = fa; data_valid = dv; data_addr = da; data_write = dw;
        @(negedge clk);
        fetch_valid = 1'b0; data_valid = 1'b0; data_write = 1'b0;
        m_stat = m_stat | exp;
        chk({tag, " exception"}, 32'(dbg_exc_o), 32'(|exp));
        chk({tag, " status"}, 32'(status_o), 32'(m_stat));
    endtask

    initial begin
        void'($urandom(32'd20241));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9 status at reset", 32'(status_o), 32'd0);
        chk("R9 exc at reset", 32'(dbg_exc_o), 32'd0);
        chk("R9 stall at reset", 32'(exact_stall_o), 32'd0);

        // R10 R2: slot0 execute, byte span, local enable
        wr(3'd0, 32'h0000_1000, "R10");
        wr(3'd4, 32'h0000_0001, "R10");
        acc(1, 32'h1000, 0, 0, 0, 4'b0001, "R2 exec hit");
        acc(1, 32'h1001, 0, 0, 0, 4'b0000, "R3 byte span miss");
        wr(3'd5, 32'h0, "R5 clear all");

        // R3: slot1 read/write, 4-byte span, global enable
        wr(3'd1, 32'h0000_2002, "R10");
        wr(3'd4, 32'h00F0_0021, "R10");
        acc(0, 0, 1, 32'h2001, 0, 4'b0010, "R3 4-byte span hit");
        acc(0, 0, 1, 32'h2004, 0, 4'b0000, "R3 4-byte span miss");
        acc(1, 32'h2002, 0, 0, 0, 4'b0000, "R4 fetch on data slot");

        // R4: slot2 write-only, byte span, local enable
        wr(3'd2, 32'h0000_3000, "R10");
        wr(3'd4, 32'h01F0_0025, "R10");
        acc(0, 0, 1, 32'h3000, 0, 4'b0000, "R4 read on write slot");
        acc(0, 0, 1, 32'h3000, 1, 4'b0100, "R4 write on write slot");
        acc(0, 0, 1, 32'h1000, 1, 4'b0000, "R4 data on exec slot");

        // R1: slot3 configured but disarmed
        wr(3'd3, 32'h0000_4000, "R10");
        acc(1, 32'h4000, 0, 0, 0, 4'b0000, "R1 disarmed slot");
        wr(3'd4, 32'h01F0_00A5, "R1 arm slot3 global");
        acc(1, 32'h4000, 0, 0, 0, 4'b1000, "R1 armed slot3");

        // R6: two slots hit together, single-cycle request
        wr(3'd3, 32'h0000_1000, "R10");
        acc(1, 32'h1000, 0, 0, 0, 4'b1001, "R6 double hit");
        acc(0, 0, 0, 0, 0, 4'b0000, "R6 request ends");

        // R5: selective clear, then sticky
        wr(3'd5, 32'hFFFF_FFFE, "R5 clear bit0");
        chk("R5 bit0 cleared", 32'(status_o[0]), 32'd0);
        acc(0, 0, 0, 0, 0, 4'b0000, "R5 sticky idle");
        fetch_valid = 1'b1; fetch_addr = 32'h1000;
        reg_wr_en = 1'b1; reg_wr_sel = 3'd5; reg_wr_data = 32'h0;
        @(negedge clk);
        fetch_valid = 1'b0; reg_wr_en = 1'b0;
        m_stat = 4'b1001;
        chk("R5 hit beats clear", 32'(status_o), 32'(m_stat));

        // R8 R7: exact bits and task switch
        wr(3'd4, m_ctrl | 32'h100, "R8 local exact");
        chk("R8 stall on local exact", 32'(exact_stall_o), 32'd1);
        tswitch("R7");
        chk("R7 local exact dropped", 32'(exact_stall_o), 32'd0);
        acc(1, 32'h1000, 0, 0, 0, 4'b1000, "R7 global slot survives");
        acc(0, 0, 1, 32'h3000, 1, 4'b0000, "R7 local slot dropped");
        wr(3'd4, m_ctrl | 32'h200, "R8 global exact");
        tswitch("R7");
        chk("R7 global exact kept", 32'(exact_stall_o), 32'd1);

        // R4: kind 10 never matches (slot2 global)
        wr(3'd4, (m_ctrl & ~32'h0F00_0000) | 32'h0200_0040, "R4");
        acc(0, 0, 1, 32'h3000, 1, 4'b0000, "R4 reserved kind write");
        acc(1, 32'h3000, 1, 32'h3000, 0, 4'b0000, "R4 reserved kind fetch+read");

        // random phase
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 16);
            if (r == 0) begin
                wr(3'($urandom % 4), 32'h1000 * (1 + $urandom % 3) + ($urandom % 4), "R10 rnd addr");
            end else if (r == 1) begin
                wr(3'd4, $urandom, "R10 rnd ctrl");
            end else if (r == 2) begin
                wr(3'd5, $urandom, "R5 rnd clear");
            end else if (r == 3) begin
                tswitch("R7 rnd");
            end else begin
                logic        fv = 1'($urandom);
                logic        dv = 1'($urandom);
                logic        dw = 1'($urandom);
                logic [31:0] fa = m_addr[$urandom % 4] ^ ($urandom % 8);
                logic [31:0] da = m_addr[$urandom % 4] ^ ($urandom % 8);
                acc(fv, fa, dv, da, dw, ref_hits(fv, fa, dv, da, dw), "R2 R3 R4 rnd access");
            end
        end

        // R9: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R9 status after reset", 32'(status_o), 32'd0);
        chk("R9 stall after reset", 32'(exact_stall_o), 32'd0);
        acc(1, 32'h1000, 1, 32'h1000, 1, 4'b0000, "R9 enables cleared");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule